// File: doc/BRIEF.md
# Tagged Arithmetic Unit with Tag-Overflow Trap

This unit adds or subtracts two 32-bit words that carry a runtime type tag in their two least significant bits. A well-formed operand has both tag bits clear. If either operand carries a nonzero tag, or if the signed arithmetic overflows, the unit does not produce a result. It raises a single tag-overflow trap strobe instead.

Each accepted operation completes one clock edge after its valid strobe. On success, the result register and the four condition flags are loaded, and a result-valid strobe is raised for one cycle. On a trap, only the trap strobe is raised. The result and flag registers keep whatever they held before the trap, so the caller sees the state of the last successful operation. Trap handling and untagged arithmetic belong to the surrounding pipeline.

Top module: `tagged_arith_unit`

## Requirements
- R1: While synchronous active-low reset is applied, and on the first cycle after it, out_valid and out_trap are 0, and out_result and out_flags are all zero.
- R2: With op_sub=0 and clean tags, out_result equals opnd_a + opnd_b modulo 2^32, with out_valid high on the cycle after the edge that sampled in_valid.
- R3: With op_sub=1 and clean tags, out_result equals opnd_a - opnd_b modulo 2^32, with the same timing as R2.
- R4: If bit 0 or bit 1 of either operand is set, the operation traps, whatever the arithmetic outcome.
- R5: An addition whose operands share a sign, and whose sum has the other sign, traps.
- R6: A subtraction whose operands differ in sign, and whose difference has a sign different from opnd_a, traps.
- R7: A trapping operation leaves out_result and out_flags at their prior values.
- R8: out_flags is {N,Z,V,C} with N at bit 3 and C at bit 0. On success, N is bit 31 of the result and Z is set when the result is zero. V is 0. C is the carry out of bit 31 for an addition, and it is the borrow (opnd_a < opnd_b unsigned) for a subtraction.
- R9: Each accepted operation raises exactly one of out_valid or out_trap, for one cycle. A tag violation together with an overflow still gives one trap pulse. Neither strobe rises without a preceding in_valid.
- R10: Operations issued on consecutive cycles each produce their own outcome on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| opnd_a | input | 32 | First operand (minuend for subtract) |
| opnd_b | input | 32 | Second operand |
| out_valid | output | 1 | Result-valid strobe |
| out_trap | output | 1 | Tag-overflow trap strobe |
| out_result | output | 32 | Result of the last successful operation |
| out_flags | output | 4 | {N,Z,V,C} of the last successful operation |

## Verification
The bench builds the unit with its default parameters: a 32-bit word and a 2-bit tag field. At these values, operands such as 0x7FFFFFFC and 0x80000000 reach the sign-boundary overflow cases of both operations. A tag value of 2 with an otherwise harmless subtraction checks the upper tag bit on its own. An operand that carries both a tag and an overflowing magnitude checks that only one trap pulse results.

// File: rtl/tagged_arith_pkg.sv
// Shared types for the tagged arithmetic unit.
// Assumes flags are packed most significant first as N, Z, V, C.
package tagged_arith_pkg;
    typedef struct packed {
        logic neg;
        logic zero;
        logic ovf;
        logic cry;
    } cc_flags_t;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } arith_op_e;
endpackage

// File: rtl/tag_guard.sv
// Detects a tag violation: any set bit in the low TAG_W bits of either operand.
// Assumes TAG_W is at least 1 and below W.
module tag_guard #(
    parameter int W     = 32,
    parameter int TAG_W = 2
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         tag_bad
);
    logic [TAG_W-1:0] bit_bad;

    // one OR per tag bit position
    for (genvar i = 0; i < TAG_W; i++) begin : g_tagbit
        assign bit_bad[i] = a[i] | b[i];
    end

    assign tag_bad = |bit_bad;
endmodule

// File: rtl/tag_arith.sv
// Computes the sum or difference, carry/borrow out, and signed overflow.
// Assumes two's-complement operands; it is purely combinational.
module tag_arith
    import tagged_arith_pkg::*;
#(
    parameter int W = 32
) (
    input  arith_op_e    op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         sovf
);
    logic [W:0] wide;

    // W+1 bit add or subtract; the top bit is the carry (add) or the borrow (sub)
    always_comb begin
        if (op == OP_SUB) wide = {1'b0, a} - {1'b0, b};
        else              wide = {1'b0, a} + {1'b0, b};
    end

    assign res  = wide[W-1:0];
    assign cout = wide[W];

    // apply the sign rule for the selected operation
    always_comb begin
        if (op == OP_SUB) sovf = (a[W-1] ^ b[W-1]) & (a[W-1] ^ res[W-1]);
        else              sovf = ~(a[W-1] ^ b[W-1]) & (a[W-1] ^ res[W-1]);
    end
endmodule

// File: rtl/tag_commit.sv
// Output register stage: it raises one strobe per accepted operation and
// loads the result and flags only when the operation did not trap.
// Assumes synchronous active-low reset.
module tag_commit
    import tagged_arith_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic         trap_req,
    input  logic [W-1:0] res_in,
    input  cc_flags_t    flg_in,
    output logic         valid_q,
    output logic         trap_q,
    output logic [W-1:0] res_q,
    output cc_flags_t    flg_q
);
    // strobe registers: one outcome per accepted operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            trap_q  <= 1'b0;
        end else begin
            valid_q <= take & ~trap_req;
            trap_q  <= take & trap_req;
        end
    end

    // architectural state: written only on success
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            flg_q <= '0;
        end else if (take && !trap_req) begin
            res_q <= res_in;
            flg_q <= flg_in;
        end
    end

    p_state_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> ($stable(res_q) && $stable(flg_q)));
endmodule

// File: rtl/tagged_arith_unit.sv
// Tagged add/subtract with a tag-overflow trap. A tag violation or a signed
// overflow traps. Otherwise the result and the {N,Z,V,C} flags are committed.
// Assumes one operation per in_valid cycle and a one-cycle latency.
module tagged_arith_unit
    import tagged_arith_pkg::*;
#(
    parameter int W     = 32,
    parameter int TAG_W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         op_sub,
    input  logic [31:0]  opnd_a,
    input  logic [31:0]  opnd_b,
    output logic         out_valid,
    output logic         out_trap,
    output logic [31:0]  out_result,
    output logic [3:0]   out_flags
);
    localparam int MSB = W - 1;

    arith_op_e   op;
    logic        tag_bad;
    logic [MSB:0] sum;
    logic        cout;
    logic        sovf;
    cc_flags_t   flg_next;
    cc_flags_t   flg_q;

    assign op = op_sub ? OP_SUB : OP_ADD;

    tag_guard #(.W(W), .TAG_W(TAG_W)) u_guard (
        .a       (opnd_a),
        .b       (opnd_b),
        .tag_bad (tag_bad)
    );

    tag_arith #(.W(W)) u_arith (
        .op   (op),
        .a    (opnd_a),
        .b    (opnd_b),
        .res  (sum),
        .cout (cout),
        .sovf (sovf)
    );

    // success flags: V is always clear because an overflow traps instead
    always_comb begin
        flg_next.neg  = sum[MSB];
        flg_next.zero = (sum == '0);
        flg_next.ovf  = 1'b0;
        flg_next.cry  = cout;
    end

    tag_commit #(.W(W)) u_commit (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (in_valid),
        .trap_req (tag_bad | sovf),
        .res_in   (sum),
        .flg_in   (flg_next),
        .valid_q  (out_valid),
        .trap_q   (out_trap),
        .res_q    (out_result),
        .flg_q    (flg_q)
    );

    assign out_flags = flg_q;

    // independent signed-range reference used by the overflow checks
    logic signed [W:0] chk_wide;
    always_comb begin
        if (op_sub) chk_wide = $signed({opnd_a[MSB], opnd_a}) - $signed({opnd_b[MSB], opnd_b});
        else        chk_wide = $signed({opnd_a[MSB], opnd_a}) + $signed({opnd_b[MSB], opnd_b});
    end

    p_tag_traps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opnd_a[TAG_W-1:0] != '0 || opnd_b[TAG_W-1:0] != '0)) |=> out_trap);
    p_add_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_sub && chk_wide[W] != chk_wide[MSB]) |=> out_trap);
    p_sub_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sub && chk_wide[W] != chk_wide[MSB]) |=> out_trap);
    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid ^ out_trap));
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_trap));
    p_v_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!out_flags[1] && out_flags[2] == (out_result == '0)));
endmodule

// File: tb/tagged_arith_unit_bench.sv
module tagged_arith_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        op_sub;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic        out_valid;
    logic        out_trap;
    logic [31:0] out_result;
    logic [3:0]  out_flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tagged_arith_unit u_tagged_arith_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid),
        .out_trap(out_trap), .out_result(out_result), .out_flags(out_flags)
    );

    // {op_sub, a, b, expect_trap, expect_result, expect_flags NZVC}
    localparam int NV = 11;
    localparam logic [101:0] VEC [NV] = '{
        {1'b0, 32'h0000_0010, 32'h0000_0020, 1'b0, 32'h0000_0030, 4'b0000}, // R2
        {1'b0, 32'hFFFF_FFFC, 32'h0000_0004, 1'b0, 32'h0000_0000, 4'b0101}, // R2 R8 carry
        {1'b0, 32'h7FFF_FFFC, 32'h0000_0004, 1'b1, 32'h0,         4'b0000}, // R5
        {1'b1, 32'h0000_0010, 32'h0000_0020, 1'b0, 32'hFFFF_FFF0, 4'b1001}, // R3 R8 borrow
        {1'b1, 32'h8000_0000, 32'h0000_0004, 1'b1, 32'h0,         4'b0000}, // R6
        {1'b0, 32'h0000_0011, 32'h0000_0004, 1'b1, 32'h0,         4'b0000}, // R4
        {1'b1, 32'h0000_0008, 32'h0000_0002, 1'b1, 32'h0,         4'b0000}, // R4 bit 1
        {1'b0, 32'h7FFF_FFFD, 32'h0000_0004, 1'b1, 32'h0,         4'b0000}, // R9 tag+ovf
        {1'b1, 32'h0000_0040, 32'h0000_0040, 1'b0, 32'h0000_0000, 4'b0100}, // R3 R8 zero
        {1'b0, 32'h8000_0000, 32'h8000_0000, 1'b1, 32'h0,         4'b0000}, // R5 negative
        {1'b1, 32'hFFFF_FFFC, 32'h7FFF_FFFC, 1'b0, 32'h8000_0000, 4'b1000}  // R6 no-ovf edge
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic [31:0] a, input logic [31:0] b);
        in_valid = 1'b1;
        op_sub   = s;
        opnd_a   = a;
        opnd_b   = b;
    endtask

    initial begin
        logic [31:0] good_res;
        logic [3:0]  good_flg;
        rst_n = 1'b0; in_valid = 1'b0; op_sub = 1'b0; opnd_a = '0; opnd_b = '0;
        repeat (3) @(negedge clk);
        chk("R1 valid", {31'b0, out_valid}, 32'h0);
        chk("R1 trap", {31'b0, out_trap}, 32'h0);
        chk("R1 result", out_result, 32'h0);
        chk("R1 flags", {28'b0, out_flags}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {30'b0, out_valid, out_trap}, 32'h0);
        good_res = '0; good_flg = '0;

        // table walk: each op followed by an idle cycle
        for (int i = 0; i < NV; i++) begin
            logic [101:0] v;
            v = VEC[i];
            drive(v[101], v[100:69], v[68:37]);
            @(negedge clk);
            in_valid = 1'b0;
            if (!v[36]) begin
                good_res = v[35:4];
                good_flg = v[3:0];
            end
            chk($sformatf("R9 valid vec%0d", i), {31'b0, out_valid}, {31'b0, ~v[36]});
            chk($sformatf("R4/R5/R6 trap vec%0d", i), {31'b0, out_trap}, {31'b0, v[36]});
            chk($sformatf("R2/R3/R7 result vec%0d", i), out_result, good_res);
            chk($sformatf("R8/R7 flags vec%0d", i), {28'b0, out_flags}, {28'b0, good_flg});
            @(negedge clk);
            chk($sformatf("R9 single pulse vec%0d", i), {30'b0, out_valid, out_trap}, 32'h0);
        end

        // R10: back-to-back add, tag trap, sub
        drive(1'b0, 32'h0000_0100, 32'h0000_0200);
        @(negedge clk);
        chk("R10 first valid", {31'b0, out_valid}, 32'h1);
        chk("R10 first result", out_result, 32'h0000_0300);
        drive(1'b1, 32'h0000_0003, 32'h0000_0000);
        @(negedge clk);
        chk("R10 second trap", {30'b0, out_valid, out_trap}, 32'h1);
        chk("R10 R7 held", out_result, 32'h0000_0300);
        drive(1'b1, 32'h0000_0300, 32'h0000_0100);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 third valid", {30'b0, out_valid, out_trap}, 32'h2);
        chk("R10 third result", out_result, 32'h0000_0200);
        chk("R8 third flags", {28'b0, out_flags}, 32'h0);

        // R1: reset clears committed state, and in_valid is ignored during reset
        rst_n = 1'b0;
        drive(1'b0, 32'h0000_0004, 32'h0000_0004);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 reset result", out_result, 32'h0);
        chk("R1 reset strobes", {30'b0, out_valid, out_trap}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 post-reset strobes", {30'b0, out_valid, out_trap}, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule